// File: doc/BRIEF.md
# Codec Mixer Register File

This block holds the sixty-four 16-bit mixer and control words of an audio codec. A host reaches them by word reads and writes at even offsets. The word index is taken from offset bits 6:1. A few offsets act on a write instead of simply storing it. Offset 0x00 starts a soft reset. The power-down word keeps a read-only status nibble. The record-select word masks what is written. The three volume words announce every write. The three sample-rate words accept a write only when their variable-rate enable bit is set in the extended audio control word.

Every word access, read or write, pulses a clear request towards the access semaphore held by the neighbouring bus-master block. An accepted rate write leaves as a one-cycle event that carries the channel and the new rate. A volume write leaves as a one-cycle event that carries the offset and the value. Read data is registered and comes back one cycle after the access.

Top module: `codec_mixer_regs`

## Requirements
- R1: After reset, word reads return these defaults: 0x8000 at offsets 0x02 and 0x1C, 0x8808 at 0x18, 0x000F at 0x26, and 0xBB80 at the rate offsets 0x2C, 0x32 and 0x34. Offset 0x00 always reads the fixed identity word 0x0140. Every other offset reads 0x0000.
- R2: A word write to offset 0x00 restores every register to its R1 default and stores nothing.
- R3: A word write to the power-down word at 0x26 stores the written value with bit 15 and bits 3:0 cleared. Bits 3:0 keep their previous content.
- R4: A word write to a volume word (0x02, 0x18, 0x1C) stores the value in full. In the next cycle vol_evt_valid is high for one cycle, with that offset on vol_evt_offset and that value on vol_evt_value.
- R5: A word write to the record-select word at 0x1A stores the written value ANDed with 0x0707.
- R6: When bit 0 of the extended audio control word at 0x2A is set, a write to 0x2C or 0x32 is stored. In the next cycle rate_evt_valid pulses, rate_evt_value carries the new rate, and rate_evt_chan is 0 for 0x2C (playback) or 1 for 0x32 (capture).
- R7: When bit 3 of 0x2A is set, a write to 0x34 is stored and raises a rate event with rate_evt_chan equal to 2 (microphone).
- R8: A rate write whose enable bit is clear stores 0xBB80 (48000) in place of the written value and raises no rate event.
- R9: Every word access, read or write, makes sema_clr high in the next cycle. A byte access does not.
- R10: A word write to an offset with no special handling stores the value unchanged.
- R11: A byte read returns 0x00FF one cycle later. A byte write changes no register.
- R12: A read gives rd_valid high for exactly the next cycle, with the register content on rd_data. A write gives no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_offset | input | 7 | Byte offset of the access |
| acc_wdata | input | 16 | Write value |
| rd_valid | output | 1 | Read data valid, one cycle after the access |
| rd_data | output | 16 | Read data |
| sema_clr | output | 1 | Clear request for the access semaphore |
| vol_evt_valid | output | 1 | Volume write event |
| vol_evt_offset | output | 7 | Offset of the volume write |
| vol_evt_value | output | 16 | Value of the volume write |
| rate_evt_valid | output | 1 | Accepted rate change event |
| rate_evt_chan | output | 2 | 0 playback, 1 capture, 2 microphone |
| rate_evt_value | output | 16 | New sample rate |

## Verification
The hardest case to reach from the ports is a rate write refused after the enable bits in 0x2A have moved. That covers refusal after an enable was set and then cleared, and refusal after a soft reset has silently cleared it. The random stimulus writes random values to 0x2A often enough that each enable bit flips in about half of the writes. It mixes these with rate writes and occasional soft resets. The bench model tracks the enable bits on its own and predicts both the stored 0xBB80 and the missing event.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  typedef enum logic [2:0] {
    K_PLAIN, K_RESET, K_PD, K_VOL, K_RECSEL, K_RATE
  } kind_t;

  typedef enum logic [1:0] {
    CH_PLAY = 2'd0, CH_CAPT = 2'd1, CH_MIC = 2'd2
  } rate_ch_t;

  localparam logic [6:0] OFS_RESET    = 7'h00;
  localparam logic [6:0] OFS_MASTER   = 7'h02;
  localparam logic [6:0] OFS_PCMOUT   = 7'h18;
  localparam logic [6:0] OFS_RECSEL   = 7'h1A;
  localparam logic [6:0] OFS_RECGAIN  = 7'h1C;
  localparam logic [6:0] OFS_PD       = 7'h26;
  localparam logic [6:0] OFS_EXT      = 7'h2A;
  localparam logic [6:0] OFS_DAC_RATE = 7'h2C;
  localparam logic [6:0] OFS_ADC_RATE = 7'h32;
  localparam logic [6:0] OFS_MIC_RATE = 7'h34;

  localparam int EXT_VRA_BIT = 0;
  localparam int EXT_VRM_BIT = 3;

  localparam logic [15:0] RATE_FALLBACK = 16'hBB80;
  localparam logic [15:0] RECSEL_KEEP   = 16'h0707;
  localparam logic [15:0] PD_WR_DROP    = 16'h800F;
  localparam logic [15:0] PD_STAT_MASK  = 16'h000F;
  localparam logic [15:0] BYTE_RD_FILL  = 16'h00FF;

  // Reset value of one word, selected by its index (offset bits 6:1).
  function automatic logic [15:0] default_word(input logic [5:0] idx);
    logic [6:0] ofs;
    ofs = {idx, 1'b0};
    case (ofs)
      OFS_MASTER, OFS_RECGAIN:                  return 16'h8000;
      OFS_PCMOUT:                               return 16'h8808;
      OFS_PD:                                   return 16'h000F;
      OFS_DAC_RATE, OFS_ADC_RATE, OFS_MIC_RATE: return RATE_FALLBACK;
      default:                                  return 16'h0000;
    endcase
  endfunction

  // Power-down write: clear bit 15, keep the old status nibble.
  function automatic logic [15:0] pd_merge(input logic [15:0] old_w,
                                           input logic [15:0] new_w);
    return (new_w & ~PD_WR_DROP) | (old_w & PD_STAT_MASK);
  endfunction

  function automatic kind_t classify(input logic [6:0] ofs);
    case (ofs)
      OFS_RESET:                                return K_RESET;
      OFS_PD:                                   return K_PD;
      OFS_MASTER, OFS_PCMOUT, OFS_RECGAIN:      return K_VOL;
      OFS_RECSEL:                               return K_RECSEL;
      OFS_DAC_RATE, OFS_ADC_RATE, OFS_MIC_RATE: return K_RATE;
      default:                                  return K_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/cmx_decode.sv
module cmx_decode
  import cmx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [DATA_W-1:0] ext_word,
  output logic              word_wr,
  output logic              word_rd,
  output logic              byte_rd,
  output kind_t             kind,
  output logic              rate_ok,
  output rate_ch_t          rate_ch
);

  assign word_wr = acc_valid &  acc_write &  acc_word;
  assign word_rd = acc_valid & ~acc_write &  acc_word;
  assign byte_rd = acc_valid & ~acc_write & ~acc_word;
  assign kind    = classify(acc_offset);

  always_comb begin
    rate_ch = CH_PLAY;
    rate_ok = 1'b0;
    case (acc_offset)
      OFS_DAC_RATE: begin rate_ch = CH_PLAY; rate_ok = ext_word[EXT_VRA_BIT]; end
      OFS_ADC_RATE: begin rate_ch = CH_CAPT; rate_ok = ext_word[EXT_VRA_BIT]; end
      OFS_MIC_RATE: begin rate_ch = CH_MIC;  rate_ok = ext_word[EXT_VRM_BIT]; end
      default: ;
    endcase
  end

endmodule

// File: rtl/cmx_regbank.sv
module cmx_regbank
  import cmx_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] CAPS_WORD = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ext_word
);

  localparam int NREG = 1 << IDX_W;
  localparam logic [IDX_W-1:0] PD_IDX  = IDX_W'(OFS_PD  >> 1);
  localparam logic [IDX_W-1:0] EXT_IDX = IDX_W'(OFS_EXT >> 1);

  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n || soft_rst)
        mem[i] <= default_word(6'(i));
      else if (wr_en && wr_idx == IDX_W'(i) && i != 0)
        mem[i] <= wr_val;
    end
  end

  assign rd_word  = (rd_idx == '0) ? CAPS_WORD : mem[rd_idx];
  assign ext_word = mem[EXT_IDX];

  logic [3:0] pd_stat;
  assign pd_stat = mem[PD_IDX][3:0];

  assert_pd_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == PD_IDX) |=> (pd_stat == $past(pd_stat)));

  assert_soft_reset_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ext_word == '0));

endmodule

// File: rtl/cmx_events.sv
module cmx_events
  import cmx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_wr,
  input  logic              word_rd,
  input  logic              byte_rd,
  input  kind_t             kind,
  input  logic              rate_ok,
  input  rate_ch_t          rate_ch,
  input  logic [ADDR_W-1:0] offset,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sema_clr,
  output logic              vol_evt_valid,
  output logic [ADDR_W-1:0] vol_evt_offset,
  output logic [DATA_W-1:0] vol_evt_value,
  output logic              rate_evt_valid,
  output rate_ch_t          rate_evt_chan,
  output logic [DATA_W-1:0] rate_evt_value
);

  logic vol_hit, rate_hit, rate_refused;
  assign vol_hit      = word_wr && kind == K_VOL;
  assign rate_hit     = word_wr && kind == K_RATE &&  rate_ok;
  assign rate_refused = word_wr && kind == K_RATE && !rate_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid       <= 1'b0;
      rd_data        <= '0;
      sema_clr       <= 1'b0;
      vol_evt_valid  <= 1'b0;
      vol_evt_offset <= '0;
      vol_evt_value  <= '0;
      rate_evt_valid <= 1'b0;
      rate_evt_chan  <= CH_PLAY;
      rate_evt_value <= '0;
    end else begin
      rd_valid       <= word_rd | byte_rd;
      rd_data        <= byte_rd ? DATA_W'(BYTE_RD_FILL) : rd_word;
      sema_clr       <= word_rd | word_wr;
      vol_evt_valid  <= vol_hit;
      rate_evt_valid <= rate_hit;
      if (vol_hit) begin
        vol_evt_offset <= offset;
        vol_evt_value  <= wr_val;
      end
      if (rate_hit) begin
        rate_evt_chan  <= rate_ch;
        rate_evt_value <= wr_val;
      end
    end
  end

  assert_sema_on_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rd || word_wr) |=> sema_clr);

  assert_refused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rate_refused |=> !rate_evt_valid);

  assert_byte_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd |=> (rd_data == DATA_W'(BYTE_RD_FILL)));

  assert_evt_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vol_evt_valid && rate_evt_valid));

endmodule

// File: rtl/codec_mixer_regs.sv
module codec_mixer_regs
  import cmx_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] CAPS_WORD = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sema_clr,
  output logic              vol_evt_valid,
  output logic [ADDR_W-1:0] vol_evt_offset,
  output logic [DATA_W-1:0] vol_evt_value,
  output logic              rate_evt_valid,
  output logic [1:0]        rate_evt_chan,
  output logic [DATA_W-1:0] rate_evt_value
);

  localparam int IDX_W = ADDR_W - 1;

  logic              word_wr, word_rd, byte_rd, rate_ok;
  kind_t             kind;
  rate_ch_t          rate_ch, evt_ch;
  logic [DATA_W-1:0] ext_word, cur_word, wr_val;
  logic [IDX_W-1:0]  idx;
  logic              soft_rst, wr_en;

  assign idx = acc_offset[ADDR_W-1:1];

  cmx_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_word  (acc_word),
    .acc_offset(acc_offset),
    .ext_word  (ext_word),
    .word_wr   (word_wr),
    .word_rd   (word_rd),
    .byte_rd   (byte_rd),
    .kind      (kind),
    .rate_ok   (rate_ok),
    .rate_ch   (rate_ch)
  );

  // Value actually stored for this write.
  always_comb begin
    case (kind)
      K_PD:     wr_val = pd_merge(cur_word, acc_wdata);
      K_RECSEL: wr_val = acc_wdata & RECSEL_KEEP;
      K_RATE:   wr_val = rate_ok ? acc_wdata : RATE_FALLBACK;
      default:  wr_val = acc_wdata;
    endcase
  end

  assign soft_rst = word_wr && kind == K_RESET;
  assign wr_en    = word_wr && kind != K_RESET;

  cmx_regbank #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CAPS_WORD(CAPS_WORD)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_val  (wr_val),
    .rd_idx  (idx),
    .rd_word (cur_word),
    .ext_word(ext_word)
  );

  cmx_events #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_wr       (word_wr),
    .word_rd       (word_rd),
    .byte_rd       (byte_rd),
    .kind          (kind),
    .rate_ok       (rate_ok),
    .rate_ch       (rate_ch),
    .offset        (acc_offset),
    .wr_val        (wr_val),
    .rd_word       (cur_word),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .sema_clr      (sema_clr),
    .vol_evt_valid (vol_evt_valid),
    .vol_evt_offset(vol_evt_offset),
    .vol_evt_value (vol_evt_value),
    .rate_evt_valid(rate_evt_valid),
    .rate_evt_chan (evt_ch),
    .rate_evt_value(rate_evt_value)
  );

  assign rate_evt_chan = evt_ch;

  assert_rd_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !rd_valid);

endmodule

// File: tb/codec_mixer_regs_bench.sv
module codec_mixer_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_word;
  logic [6:0]  acc_offset;
  logic [15:0] acc_wdata;
  logic        rd_valid, sema_clr, vol_evt_valid, rate_evt_valid;
  logic [15:0] rd_data, vol_evt_value, rate_evt_value;
  logic [6:0]  vol_evt_offset;
  logic [1:0]  rate_evt_chan;

  always #5 clk = ~clk;

  codec_mixer_regs u_codec_mixer_regs (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sema_clr(sema_clr),
    .vol_evt_valid(vol_evt_valid), .vol_evt_offset(vol_evt_offset),
    .vol_evt_value(vol_evt_value), .rate_evt_valid(rate_evt_valid),
    .rate_evt_chan(rate_evt_chan), .rate_evt_value(rate_evt_value)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m [64];

  function automatic logic [15:0] b_def(input int i);
    case (i)
      1, 14:      return 16'h8000;   // 0x02, 0x1C
      12:         return 16'h8808;   // 0x18
      19:         return 16'h000F;   // 0x26
      22, 25, 26: return 16'hBB80;   // 0x2C, 0x32, 0x34
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] b_read(input int i);
    return (i == 0) ? 16'h0140 : m[i];
  endfunction

  function automatic string tag_of(input logic wr, input logic wd, input logic [6:0] o);
    if (!wd) return "R11";
    if (!wr) return "R12";
    case (o)
      7'h00: return "R2";
      7'h26: return "R3";
      7'h02, 7'h18, 7'h1C: return "R4";
      7'h1A: return "R5";
      7'h2C, 7'h32: return "R6";
      7'h34: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m[i] = b_def(i);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic acc(input string req, input logic wr, input logic wd,
                     input logic [6:0] o, input logic [15:0] v);
    int          i;
    logic        e_vol, e_rate, en;
    logic [15:0] e_rd;
    logic [1:0]  e_ch;
    i      = int'(o[6:1]);
    e_rd   = wd ? b_read(i) : 16'h00FF;
    e_vol  = wr && wd && (o == 7'h02 || o == 7'h18 || o == 7'h1C);
    en     = (o == 7'h34) ? m[21][3] : m[21][0];
    e_rate = wr && wd && (o == 7'h2C || o == 7'h32 || o == 7'h34) && en;
    e_ch   = (o == 7'h2C) ? 2'd0 : (o == 7'h32) ? 2'd1 : 2'd2;
    if (wr && wd) begin
      case (o)
        7'h00: model_reset();
        7'h26: m[i] = (v & 16'h7FF0) | (m[i] & 16'h000F);
        7'h1A: m[i] = v & 16'h0707;
        7'h2C, 7'h32, 7'h34: m[i] = en ? v : 16'hBB80;
        default: m[i] = v;
      endcase
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_word = wd; acc_offset = o; acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(wr ? "R12" : req, "rd_valid", 32'(rd_valid), 32'(!wr));
    if (!wr) chk(req, "rd_data", 32'(rd_data), 32'(e_rd));
    chk("R9", "sema_clr", 32'(sema_clr), 32'(wd));
    chk(e_vol ? "R4" : req, "vol_evt_valid", 32'(vol_evt_valid), 32'(e_vol));
    if (e_vol) begin
      chk("R4", "vol_evt_offset", 32'(vol_evt_offset), 32'(o));
      chk("R4", "vol_evt_value", 32'(vol_evt_value), 32'(v));
    end
    chk(e_rate ? req : (wr && wd && o >= 7'h2C && o <= 7'h34 && o[6:1] != 6'h15 ? "R8" : req),
        "rate_evt_valid", 32'(rate_evt_valid), 32'(e_rate));
    if (e_rate) begin
      chk(req, "rate_evt_chan", 32'(rate_evt_chan), 32'(e_ch));
      chk(req, "rate_evt_value", 32'(rate_evt_value), 32'(v));
    end
  endtask

  task automatic rd_chk(input string req, input logic [6:0] o);
    acc(req, 1'b0, 1'b1, o, 16'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] pick [10];
    pick = '{7'h02, 7'h18, 7'h1A, 7'h1C, 7'h26, 7'h2A, 7'h2C, 7'h32, 7'h34, 7'h3A};
    void'($urandom(32'd2024));
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_word = 1'b1;
    acc_offset = '0; acc_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs and reset defaults
    chk("R1", "rd_valid idle", 32'(rd_valid), 32'd0);
    chk("R1", "sema_clr idle", 32'(sema_clr), 32'd0);
    foreach (pick[k]) rd_chk("R1", pick[k]);
    rd_chk("R1", 7'h00);
    // R8: rate writes refused while the enables are clear
    acc("R8", 1'b1, 1'b1, 7'h2C, 16'h5622); rd_chk("R8", 7'h2C);
    acc("R8", 1'b1, 1'b1, 7'h34, 16'h3E80); rd_chk("R8", 7'h34);
    // R6: variable-rate audio enabled
    acc("R10", 1'b1, 1'b1, 7'h2A, 16'h0001);
    acc("R6", 1'b1, 1'b1, 7'h2C, 16'h5622); rd_chk("R6", 7'h2C);
    acc("R6", 1'b1, 1'b1, 7'h32, 16'h2B11); rd_chk("R6", 7'h32);
    acc("R8", 1'b1, 1'b1, 7'h34, 16'h1F40); rd_chk("R8", 7'h34);
    // R7: variable-rate mic enabled
    acc("R10", 1'b1, 1'b1, 7'h2A, 16'h0009);
    acc("R7", 1'b1, 1'b1, 7'h34, 16'h3E80); rd_chk("R7", 7'h34);
    // R3: power-down status nibble kept, bit 15 dropped
    acc("R3", 1'b1, 1'b1, 7'h26, 16'hFFF0); rd_chk("R3", 7'h26);
    // R5: record select masked
    acc("R5", 1'b1, 1'b1, 7'h1A, 16'hFFFF); rd_chk("R5", 7'h1A);
    // R4: volume event
    acc("R4", 1'b1, 1'b1, 7'h02, 16'h1234); rd_chk("R4", 7'h02);
    // R10: plain store
    acc("R10", 1'b1, 1'b1, 7'h3A, 16'hABCD); rd_chk("R10", 7'h3A);
    // R11: byte read fill, byte write ignored
    acc("R11", 1'b0, 1'b0, 7'h02, 16'h0);
    acc("R11", 1'b1, 1'b0, 7'h02, 16'h5555); rd_chk("R11", 7'h02);
    // R2: soft reset restores defaults
    acc("R2", 1'b1, 1'b1, 7'h00, 16'hFFFF);
    foreach (pick[k]) rd_chk("R2", pick[k]);
    acc("R8", 1'b1, 1'b1, 7'h2C, 16'h7D00); rd_chk("R8", 7'h2C);
    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [6:0]  o;
      logic        wr, wd;
      logic [15:0] v;
      int          r;
      r  = int'($urandom_range(0, 99));
      o  = (r < 2) ? 7'h00 : (r < 80) ? pick[$urandom_range(0, 9)]
                                      : {6'($urandom_range(1, 63)), 1'b0};
      wr = ($urandom_range(0, 1) == 1);
      wd = ($urandom_range(0, 9) != 0);
      v  = 16'($urandom);
      acc(tag_of(wr, wd, o), wr, wd, o, v);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule